// File: doc/BRIEF.md
# Coalescing Write Buffer

This block sits between a write-through data cache and the memory system. Each processor store is one word. The block takes the store at once, so the processor keeps running while memory is busy. Each slot in the buffer covers one aligned block of several words. A slot keeps a bit for each word that marks it as written. A new store is compared with every slot that is still waiting. If it falls in the same block as a waiting slot that is not yet on the memory port, the store is folded into that slot and no fresh slot is used. Memory therefore sees one block write with a word mask, not a string of single-word writes.

Slots leave in the order they were allocated. The oldest slot is shown on the memory port as soon as it exists. While it is shown, it is frozen: it takes no more stores, and its address, mask and data stay still until memory accepts them. A probe port takes a read address and reports whether any waiting slot holds a word at that address. This lets a load go ahead of the buffered stores without returning stale data.

Addresses are word addresses. The low `log2(WORDS)` bits select the word inside a block, and the remaining upper bits form the block address.

Top module: `merge_wbuf`

## Requirements
- R1: After synchronous reset, `wr_ready` is 1, `mem_valid` is 0 and `probe_hit` is 0.
- R2: A store that cannot merge fills a free slot. That slot presents `mem_blk_addr` = address / WORDS. Its `mem_mask` has only bit (address % WORDS) set. Its `mem_data` holds the store data in bits [DATA_W*w +: DATA_W], where w = address % WORDS, and zero in every other word.
- R3: A store whose block matches a waiting slot other than the oldest is merged into that slot. The store sets that word's mask bit and replaces that word's data. A later store to the same word overwrites the earlier one.
- R4: The oldest slot, which is the one on the memory port, accepts no merges. A store to its block takes a new slot. While `mem_valid` is 1 and `mem_ready` is 0, `mem_blk_addr`, `mem_mask` and `mem_data` do not change.
- R5: Slots reach memory in allocation order, one block per cycle in which `mem_valid` and `mem_ready` are both 1.
- R6: When all NUM_ENT slots are occupied, `wr_ready` is 0 for a store that cannot merge. It is 1 for a store that merges into a slot other than the oldest.
- R7: `probe_hit` is 1 exactly when some waiting slot, the oldest included, has block address probe_addr / WORDS and its mask bit (probe_addr % WORDS) set.
- R8: A store and a memory handshake in the same cycle both take effect.
- R9: `mem_valid` is 1 whenever at least one slot is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Processor store request |
| wr_ready | output | 1 | Store can be accepted this cycle |
| wr_addr | input | ADDR_W | Store word address |
| wr_data | input | DATA_W | Store data |
| mem_valid | output | 1 | Block write offered to memory |
| mem_ready | input | 1 | Memory accepts the offered block |
| mem_blk_addr | output | ADDR_W-log2(WORDS) | Block address of the offered write |
| mem_mask | output | WORDS | Per-word write enable |
| mem_data | output | WORDS*DATA_W | Block data, word w at bits [DATA_W*w +: DATA_W] |
| probe_addr | input | ADDR_W | Read word address to look up |
| probe_hit | output | 1 | A waiting slot holds the probed word |

## Verification
The hardest overlap is a store arriving in the same cycle that memory accepts the oldest slot. The store may target the block that is leaving, which must allocate a new slot. It may instead target a younger slot, which must merge. The bench provokes this with long runs of random stores over a few blocks while `mem_ready` toggles at random, and with directed cases that fill the buffer. Every cycle, a queue model in the bench that shifts on each drain predicts `wr_ready`, the memory port contents and the probe result, and these are compared against the design.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
    localparam int DATA_W = 32;
    localparam int WORDS  = 4;
    localparam int ADDR_W = 16;
    localparam int OFS_W  = $clog2(WORDS);
    localparam int BLK_W  = ADDR_W - OFS_W;

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [OFS_W-1:0]  wsel_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic                         vld;
        blk_t                         blk;
        logic [WORDS-1:0]             wmask;
        logic [WORDS-1:0][DATA_W-1:0] data;
    } slot_t;

    function automatic blk_t blk_of(addr_t a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic wsel_t word_of(addr_t a);
        return a[OFS_W-1:0];
    endfunction
endpackage

// File: rtl/mwb_order.sv
module mwb_order #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);
    logic [IDX_W:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (push) tail <= (tail == LAST) ? '0 : tail + 1'b1;
            if (pop)  head <= (head == LAST) ? '0 : head + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign full  = (cnt == (IDX_W+1)'(N));
    assign empty = (cnt == '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/mwb_slot.sv
module mwb_slot
    import mwb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  alloc,
    input  logic  merge,
    input  logic  clear,
    input  blk_t  blk,
    input  wsel_t wsel,
    input  word_t wdata,
    output slot_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (clear) begin
                st.vld   <= 1'b0;
                st.wmask <= '0;
            end
            if (alloc) begin
                st.vld         <= 1'b1;
                st.blk         <= blk;
                st.wmask       <= '0;
                st.wmask[wsel] <= 1'b1;
                st.data        <= '0;
                st.data[wsel]  <= wdata;
            end else if (merge) begin
                st.wmask[wsel] <= 1'b1;
                st.data[wsel]  <= wdata;
            end
        end
    end

    p_alloc_free_slot_r2: assert property (@(posedge clk) disable iff (rst) alloc |-> !st.vld);
    p_merge_live_slot_r3: assert property (@(posedge clk) disable iff (rst) merge |-> (st.vld && !clear));
endmodule

// File: rtl/mwb_match.sv
module mwb_match
    import mwb_pkg::*;
#(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_t            slots [N],
    input  logic [IDX_W-1:0] head,
    input  blk_t             wr_blk,
    input  blk_t             pr_blk,
    input  wsel_t            pr_wsel,
    output logic             merge_hit,
    output logic [IDX_W-1:0] merge_idx,
    output logic             probe_hit
);
    logic [N-1:0] mhit;
    logic [N-1:0] phit;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign mhit[i] = slots[i].vld && (slots[i].blk == wr_blk) && (IDX_W'(i) != head);
        assign phit[i] = slots[i].vld && (slots[i].blk == pr_blk) && slots[i].wmask[pr_wsel];
    end

    always_comb begin
        merge_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mhit[i]) merge_idx = IDX_W'(i);
        end
    end

    assign merge_hit = |mhit;
    assign probe_hit = |phit;

    p_single_target_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(mhit));
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
    import mwb_pkg::*;
#(
    parameter int NUM_ENT = 4,
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [BLK_W-1:0]        mem_blk_addr,
    output logic [WORDS-1:0]        mem_mask,
    output logic [WORDS*DATA_W-1:0] mem_data,
    input  logic [ADDR_W-1:0]       probe_addr,
    output logic                    probe_hit
);
    slot_t            slots [NUM_ENT];
    logic [IDX_W-1:0] head, tail, merge_idx;
    logic             full, empty, merge_hit;
    logic             wr_fire, do_merge, do_alloc, drain;

    mwb_match #(.N(NUM_ENT)) u_match (
        .clk(clk), .rst(rst), .slots(slots), .head(head),
        .wr_blk(blk_of(wr_addr)), .pr_blk(blk_of(probe_addr)),
        .pr_wsel(word_of(probe_addr)),
        .merge_hit(merge_hit), .merge_idx(merge_idx), .probe_hit(probe_hit)
    );

    assign wr_ready = merge_hit || !full;
    assign wr_fire  = wr_valid && wr_ready;
    assign do_merge = wr_fire && merge_hit;
    assign do_alloc = wr_fire && !merge_hit;
    assign drain    = mem_valid && mem_ready;

    mwb_order #(.N(NUM_ENT)) u_order (
        .clk(clk), .rst(rst), .push(do_alloc), .pop(drain),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
        mwb_slot u_slot (
            .clk(clk), .rst(rst),
            .alloc(do_alloc && (tail == IDX_W'(i))),
            .merge(do_merge && (merge_idx == IDX_W'(i))),
            .clear(drain && (head == IDX_W'(i))),
            .blk(blk_of(wr_addr)), .wsel(word_of(wr_addr)), .wdata(wr_data),
            .st(slots[i])
        );
    end

    assign mem_valid    = !empty;
    assign mem_blk_addr = slots[head].blk;
    assign mem_mask     = slots[head].wmask;
    assign mem_data     = slots[head].data;

    p_hold_offer_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_blk_addr)
                                       && $stable(mem_mask) && $stable(mem_data)));
    p_mask_present_r2: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_mask != '0));
    p_stall_needs_backlog_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |-> mem_valid);
    p_store_lands_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> mem_valid);
endmodule

// File: tb/merge_wbuf_bench.sv
module merge_wbuf_bench;
    import mwb_pkg::*;
    localparam int  N   = 4;
    localparam time CLK = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_valid = 1'b0, mem_ready = 1'b0;
    logic wr_ready, mem_valid, probe_hit;
    logic [ADDR_W-1:0] wr_addr = '0, probe_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [BLK_W-1:0] mem_blk_addr;
    logic [WORDS-1:0] mem_mask;
    logic [WORDS*DATA_W-1:0] mem_data;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [BLK_W-1:0]  m_blk  [N];
    logic [WORDS-1:0]  m_mask [N];
    logic [DATA_W-1:0] m_data [N][WORDS];
    int m_cnt = 0;

    merge_wbuf #(.NUM_ENT(N)) u_merge_wbuf (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_blk_addr(mem_blk_addr), .mem_mask(mem_mask),
        .mem_data(mem_data), .probe_addr(probe_addr), .probe_hit(probe_hit)
    );

    always #(CLK/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [WORDS*DATA_W-1:0] act, input logic [WORDS*DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit wv, input int wa, input logic [DATA_W-1:0] wd,
                        input bit mr, input int pa, input string tag);
        int  hit_j;
        bit  e_ready, e_mv, e_probe;
        logic [WORDS*DATA_W-1:0] e_data;
        @(negedge clk);
        wr_valid = wv; wr_addr = ADDR_W'(wa); wr_data = wd;
        mem_ready = mr; probe_addr = ADDR_W'(pa);
        #1;
        hit_j = -1;
        for (int j = 1; j < m_cnt; j++)
            if (m_blk[j] == BLK_W'(wa / WORDS)) hit_j = j;
        e_ready = (hit_j >= 0) || (m_cnt < N);
        e_mv = (m_cnt > 0);
        e_probe = 0;
        for (int j = 0; j < m_cnt; j++)
            if (m_blk[j] == BLK_W'(pa / WORDS) && m_mask[j][pa % WORDS]) e_probe = 1;
        chk(wr_ready == e_ready, tag, "wr_ready", wr_ready, e_ready);
        chk(mem_valid == e_mv, tag, "mem_valid", mem_valid, e_mv);
        chk(probe_hit == e_probe, tag, "probe_hit", probe_hit, e_probe);
        if (e_mv) begin
            for (int w = 0; w < WORDS; w++) e_data[w*DATA_W +: DATA_W] = m_data[0][w];
            chk(mem_blk_addr == m_blk[0], tag, "mem_blk_addr", mem_blk_addr, m_blk[0]);
            chk(mem_mask == m_mask[0], tag, "mem_mask", mem_mask, m_mask[0]);
            chk(mem_data == e_data, tag, "mem_data", mem_data, e_data);
        end
        if (wv && e_ready) begin
            if (hit_j >= 0) begin
                m_mask[hit_j][wa % WORDS] = 1'b1;
                m_data[hit_j][wa % WORDS] = wd;
            end else begin
                m_blk[m_cnt]  = BLK_W'(wa / WORDS);
                m_mask[m_cnt] = '0;
                m_mask[m_cnt][wa % WORDS] = 1'b1;
                for (int w = 0; w < WORDS; w++) m_data[m_cnt][w] = '0;
                m_data[m_cnt][wa % WORDS] = wd;
                m_cnt++;
            end
        end
        if (e_mv && mr) begin
            for (int j = 0; j < N - 1; j++) begin
                m_blk[j] = m_blk[j+1]; m_mask[j] = m_mask[j+1];
                for (int w = 0; w < WORDS; w++) m_data[j][w] = m_data[j+1][w];
            end
            m_cnt--;
        end
    endtask

    task automatic drain_all(input string tag);
        for (int k = 0; k < 2 * N && m_cnt > 0; k++) step(0, 0, 0, 1, 0, tag);
        step(0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        step(0, 0, 0, 0, 0, "R1");
        // R2: lone store, word 2 of block 4, then drained
        step(1, 18, 32'hA5A5_0001, 0, 18, "R2");
        step(0, 0, 0, 0, 18, "R2");
        step(0, 0, 0, 0, 19, "R2");
        drain_all("R2");
        // R3: merges into younger slot, word overwrite
        step(1, 4, 32'h1111, 0, 0, "R3");
        step(1, 9, 32'h2222, 0, 9, "R3");
        step(1, 11, 32'h3333, 0, 11, "R3");
        step(1, 9, 32'h4444, 0, 9, "R3");
        step(1, 8, 32'h5555, 0, 8, "R3");
        drain_all("R3");
        // R4: store to head block allocates, head held still
        step(1, 20, 32'h6666, 0, 20, "R4");
        step(1, 21, 32'h7777, 0, 21, "R4");
        step(1, 22, 32'h8888, 0, 22, "R4");
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 21, "R4");
        drain_all("R4");
        // R6: fill, stall a new block, accept a merge while full
        for (int b = 0; b < N; b++) step(1, b * WORDS, 32'h100 + b, 0, 0, "R6");
        step(1, 40, 32'hDEAD, 0, 40, "R6");
        step(1, 2 * WORDS + 3, 32'hBEEF, 0, 0, "R6");
        step(1, 1, 32'hCAFE, 0, 0, "R6");
        // R7: probe sweep over a filled buffer
        for (int a = 0; a < 8 * WORDS; a++) step(0, 0, 0, 0, a, "R7");
        // R8: stall released by a drain, store in same cycle
        step(1, 40, 32'hF00D, 1, 40, "R8");
        step(1, 41, 32'hF00E, 1, 41, "R8");
        drain_all("R5");
        // R5 / R8 / R9: random stores over few blocks with random backpressure
        for (int k = 0; k < 4000; k++)
            step(($urandom % 3) != 0, $urandom % (6 * WORDS), $urandom,
                 ($urandom % 4) == 0, $urandom % (6 * WORDS), "R8");
        drain_all("R5");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule